// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Pending and Vector Unit

This unit gathers interrupt requests from the two channels of a dual serial controller and drives a single interrupt request line. Each channel offers three sources: a received character, an emptied transmit buffer and a change on its external/status inputs. The unit owns the pending register, which software reads through channel A, and the interrupt vector, which software reads through channel B. When vector status mode is on, the vector's low bits tell software which event caused the interrupt and whether it came from channel A.

Software clears pending sources by writing reset commands into the command field of the channel's command register. The unit decodes that field, clears the selected sources and updates the vector. It then pulses a strobe that tells the surrounding register file to wipe the command and pointer fields. The register storage, the data path and the serial line are outside this unit. Their events reach it as single-cycle pulses, and their enables reach it as levels.

Within one cycle, the unit applies the last-character-read clears first, then the command, then new events. New events are taken in the order channel A before channel B, and receive, then transmit, then external/status within a channel.

Top module: `sio_irq_vector`

## Requirements
- R1: After reset, `pend_rd` is 0x00, `vec_rd` is {VEC_BASE, 4'b0110}, and `irq` and `wr0_clr` are low.
- R2: `pend_rd` bit 5/4/3 is receive/transmit/external pending for channel A, and bit 2/1/0 the same for channel B (bits 7:6 read 0). A receive request sets its bit only when `mie`, that channel's `rx_ie` and `rx_arrive` are all high and no receive interrupt is already pending for that channel.
- R3: A `tx_done` pulse sets the transmit bit only when that channel's `tx_ie` is high. An `xs_evt` pulse sets the external bit only when that channel's `xs_ie` is high. Otherwise the pending register is unchanged.
- R4: When `vis_en` is high and an event is recorded, the vector is updated as follows. If nothing was pending, `vec_rd[3:1]` is first cleared. Then receive ORs in bit 2, external/status ORs in bit 1 and transmit adds nothing; a channel A event also sets bit 3. When `vis_en` is low, recording leaves `vec_rd` unchanged.
- R5: Command code 3'b010 (`cmd_code` = command register bits 5:3) clears the selected channel's external pending bit. It clears vector bit 1 only if the other channel has no external interrupt pending.
- R6: Command code 3'b101 clears the selected channel's transmit pending bit and leaves the vector status bits unchanged.
- R7: Command code 3'b111 clears only the selected channel's highest pending source, in the order receive, transmit, external. A cleared receive source clears vector bit 2, and a cleared external source clears vector bit 1, only when the other channel has no interrupt of that kind pending.
- R8: After any recognised command, vector bit 3 is cleared if none of channel A's pending bits remain set.
- R9: If a recognised command leaves the pending register all zero while `vis_en` is high, `vec_rd[3:1]` becomes 3'b011.
- R10: An `rx_last_rd` pulse clears that channel's receive pending bit and does not change the vector.
- R11: `irq` is a registered active-high output that is high exactly when `pend_rd` is nonzero.
- R12: `wr0_clr` pulses high for one cycle, in the cycle after a recognised command is written. Any other code has no effect on `pend_rd`, `vec_rd`, `irq` or `wr0_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mie | input | 1 | Master interrupt enable |
| vis_en | input | 1 | Vector status mode enable |
| rx_ie | input | 2 | Receive interrupt enable per channel (bit 0 = A) |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| xs_ie | input | 2 | External/status interrupt enable per channel |
| rx_arrive | input | 2 | Character queued pulse per channel |
| rx_last_rd | input | 2 | Last queued character read pulse per channel |
| tx_done | input | 2 | Transmit complete pulse per channel |
| xs_evt | input | 2 | External/status change pulse per channel |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_chan | input | 1 | Channel written (0 = A, 1 = B) |
| cmd_code | input | 3 | Command field, register bits 5:3 |
| pend_rd | output | 8 | Pending register as read through channel A |
| vec_rd | output | 8 | Interrupt vector as read through channel B |
| irq | output | 1 | Interrupt request, active high |
| wr0_clr | output | 1 | Strobe to clear command and pointer fields |

## Verification
A wrong pending bit shows up at `pend_rd` and `irq` in the very next cycle. A wrong vector flag, however, can stay hidden until the pending register drains, or until a reset-highest command picks the wrong source. The bench therefore builds sequences in which both channels hold interrupts of the same kind, and then checks the cross-channel conditions on vector bits 1 and 2 and the channel A bit 3. Every command is followed by a check of the special-receive default and the one-cycle strobe in the cycle after it.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int NCH   = 2;
  localparam int NKIND = 3;
  localparam int NPEND = NCH * NKIND;

  // source kinds: also bit offset inside a channel's pending group
  localparam logic [1:0] K_XS = 2'd0;
  localparam logic [1:0] K_TX = 2'd1;
  localparam logic [1:0] K_RX = 2'd2;

  // command field values (command register bits 5:3)
  localparam logic [2:0] CMD_RST_XS  = 3'b010;
  localparam logic [2:0] CMD_RST_TX  = 3'b101;
  localparam logic [2:0] CMD_RST_IUS = 3'b111;

  // vector low nibble fields
  localparam logic [3:0] VIS_CHA  = 4'b1000;
  localparam logic [3:0] VIS_MASK = 4'b1110;
  localparam logic [3:0] VIS_SRC  = 4'b0110;

  // pending bit position: channel A (0) sits above channel B (1)
  function automatic logic [2:0] pend_bit(input logic ch, input logic [1:0] k);
    return ch ? {1'b0, k} : ({1'b0, k} + 3'd3);
  endfunction

  function automatic logic [3:0] vis_flag(input logic [1:0] k);
    case (k)
      K_RX:    return 4'b0100;
      K_XS:    return 4'b0010;
      default: return 4'b0000;
    endcase
  endfunction

  // vector update when an event is recorded in status mode
  function automatic logic [3:0] vis_record(input logic [3:0] v, input logic was_empty,
                                            input logic [1:0] k, input logic ch);
    logic [3:0] r;
    r = was_empty ? (v & ~VIS_MASK) : v;
    r = r | vis_flag(k);
    if (!ch) r = r | VIS_CHA;
    return r;
  endfunction

  function automatic logic cmd_known(input logic [2:0] c);
    return (c == CMD_RST_XS) || (c == CMD_RST_TX) || (c == CMD_RST_IUS);
  endfunction

endpackage

// File: rtl/irq_req_qual.sv
module irq_req_qual
  import irq_vec_pkg::*;
#(
  parameter int CH = NCH
) (
  input  logic                  mie,
  input  logic [CH-1:0]         rx_ie,
  input  logic [CH-1:0]         tx_ie,
  input  logic [CH-1:0]         xs_ie,
  input  logic [CH-1:0]         rx_arrive,
  input  logic [CH-1:0]         tx_done,
  input  logic [CH-1:0]         xs_evt,
  input  logic [CH-1:0]         rx_busy,
  output logic [CH*NKIND-1:0]   req
);
  for (genvar g = 0; g < CH; g++) begin : g_ch
    assign req[g*NKIND + int'(K_RX)] = mie & rx_ie[g] & rx_arrive[g] & ~rx_busy[g];
    assign req[g*NKIND + int'(K_TX)] = tx_ie[g] & tx_done[g];
    assign req[g*NKIND + int'(K_XS)] = xs_ie[g] & xs_evt[g];
  end
endmodule

// File: rtl/irq_cmd_dec.sv
module irq_cmd_dec
  import irq_vec_pkg::*;
(
  input  logic             cmd_wr,
  input  logic [2:0]       cmd_code,
  input  logic [NKIND-1:0] chan_pend,
  output logic [NKIND-1:0] clr,
  output logic             hit
);
  always_comb begin
    clr = '0;
    hit = cmd_wr & cmd_known(cmd_code);
    if (cmd_wr) begin
      case (cmd_code)
        CMD_RST_XS: clr[K_XS] = 1'b1;
        CMD_RST_TX: clr[K_TX] = 1'b1;
        CMD_RST_IUS: begin
          if (chan_pend[K_RX])      clr[K_RX] = 1'b1;
          else if (chan_pend[K_TX]) clr[K_TX] = 1'b1;
          else if (chan_pend[K_XS]) clr[K_XS] = 1'b1;
        end
        default: clr = '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
  import irq_vec_pkg::*;
#(
  parameter logic [3:0] VEC_BASE = 4'h0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mie,
  input  logic       vis_en,
  input  logic [1:0] rx_ie,
  input  logic [1:0] tx_ie,
  input  logic [1:0] xs_ie,
  input  logic [1:0] rx_arrive,
  input  logic [1:0] rx_last_rd,
  input  logic [1:0] tx_done,
  input  logic [1:0] xs_evt,
  input  logic       cmd_wr,
  input  logic       cmd_chan,
  input  logic [2:0] cmd_code,
  output logic [7:0] pend_rd,
  output logic [7:0] vec_rd,
  output logic       irq,
  output logic       wr0_clr
);
  localparam int PAD = 8 - NPEND;

  logic [NPEND-1:0] pend_q, pend_rdclr, pend_cmd, pend_nxt;
  logic [3:0]       vec_q, vec_cmd, vec_nxt;
  logic             irq_q, clr_q;
  logic [NKIND-1:0] sel_pend, cmd_clr;
  logic             cmd_hit;
  logic [NPEND-1:0] req;
  logic [NCH-1:0]   rx_busy;

  // stage 1: last character read
  always_comb begin
    pend_rdclr = pend_q;
    for (int c = 0; c < NCH; c++)
      if (rx_last_rd[c]) pend_rdclr[pend_bit(1'(c), K_RX)] = 1'b0;
  end

  assign sel_pend = cmd_chan ? pend_rdclr[2:0] : pend_rdclr[5:3];

  irq_cmd_dec u_dec (
    .cmd_wr   (cmd_wr),
    .cmd_code (cmd_code),
    .chan_pend(sel_pend),
    .clr      (cmd_clr),
    .hit      (cmd_hit)
  );

  // stage 2: command
  always_comb begin
    pend_cmd = pend_rdclr;
    vec_cmd  = vec_q;
    for (int k = 0; k < NKIND; k++)
      if (cmd_clr[k]) pend_cmd[pend_bit(cmd_chan, 2'(k))] = 1'b0;
    if (cmd_clr[K_RX] && !pend_cmd[pend_bit(~cmd_chan, K_RX)])
      vec_cmd = vec_cmd & ~vis_flag(K_RX);
    if (cmd_clr[K_XS] && !pend_cmd[pend_bit(~cmd_chan, K_XS)])
      vec_cmd = vec_cmd & ~vis_flag(K_XS);
    if (cmd_hit) begin
      if (pend_cmd[5:3] == '0) vec_cmd = vec_cmd & ~VIS_CHA;
      if (pend_cmd == '0 && vis_en) vec_cmd = (vec_cmd & ~VIS_MASK) | VIS_SRC;
    end
  end

  assign rx_busy = {pend_cmd[pend_bit(1'b1, K_RX)], pend_cmd[pend_bit(1'b0, K_RX)]};

  irq_req_qual #(.CH(NCH)) u_qual (
    .mie      (mie),
    .rx_ie    (rx_ie),
    .tx_ie    (tx_ie),
    .xs_ie    (xs_ie),
    .rx_arrive(rx_arrive),
    .tx_done  (tx_done),
    .xs_evt   (xs_evt),
    .rx_busy  (rx_busy),
    .req      (req)
  );

  // stage 3: record new events, channel A first, rx/tx/xs order
  always_comb begin
    pend_nxt = pend_cmd;
    vec_nxt  = vec_cmd;
    for (int c = 0; c < NCH; c++) begin
      for (int k = NKIND - 1; k >= 0; k--) begin
        if (req[c*NKIND + k]) begin
          if (vis_en) vec_nxt = vis_record(vec_nxt, pend_nxt == '0, 2'(k), 1'(c));
          pend_nxt[pend_bit(1'(c), 2'(k))] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      vec_q  <= VIS_SRC;
      irq_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      vec_q  <= vec_nxt;
      irq_q  <= |pend_nxt;
      clr_q  <= cmd_hit;
    end
  end

  assign pend_rd = {{PAD{1'b0}}, pend_q};
  assign vec_rd  = {VEC_BASE, vec_q};
  assign irq     = irq_q;
  assign wr0_clr = clr_q;

  // R11
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (pend_q != '0));

  // R9
  src_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && vis_en) |=> (pend_q != '0 || vec_q[3:1] == 3'b011));

  // R8
  cha_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> (pend_q[5:3] != '0 || !vec_q[3]));

  // R12
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_known(cmd_code)) |=> !wr0_clr);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    localparam logic [2:0] BRX = pend_bit(1'(g), K_RX);
    localparam logic [2:0] BTX = pend_bit(1'(g), K_TX);
    localparam logic [2:0] BXS = pend_bit(1'(g), K_XS);
    // R2
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[BRX]) |-> $past(mie && rx_ie[g] && rx_arrive[g]));
    // R3
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[BTX]) |-> $past(tx_ie[g] && tx_done[g]));
    // R3
    xs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[BXS]) |-> $past(xs_ie[g] && xs_evt[g]));
    // R7
    ius_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_chan == 1'(g) && cmd_code == CMD_RST_IUS && pend_rdclr[BRX] && pend_q[BTX])
      |=> pend_q[BTX]);
    // R10
    last_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_last_rd[g] && !rx_arrive[g]) |=> !pend_q[BRX]);
  end

endmodule

// File: tb/test_sio_irq_vector.sv
module test_sio_irq_vector;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mie, vis_en;
  logic [1:0] rx_ie, tx_ie, xs_ie, rx_arrive, rx_last_rd, tx_done, xs_evt;
  logic       cmd_wr, cmd_chan;
  logic [2:0] cmd_code;
  logic [7:0] pend_rd, vec_rd;
  logic       irq, wr0_clr;

  always #5 clk = ~clk;

  sio_irq_vector i_sio_irq_vector (
    .clk(clk), .rst_n(rst_n), .mie(mie), .vis_en(vis_en),
    .rx_ie(rx_ie), .tx_ie(tx_ie), .xs_ie(xs_ie),
    .rx_arrive(rx_arrive), .rx_last_rd(rx_last_rd), .tx_done(tx_done), .xs_evt(xs_evt),
    .cmd_wr(cmd_wr), .cmd_chan(cmd_chan), .cmd_code(cmd_code),
    .pend_rd(pend_rd), .vec_rd(vec_rd), .irq(irq), .wr0_clr(wr0_clr)
  );

  typedef struct {
    logic [7:0] p;
    logic [7:0] v;
    logic       i;
    logic       w;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference state: m_p bit layout per R2, kinds rx=2 tx=1 xs=0
  logic [5:0] m_p;
  logic [3:0] m_v;

  function automatic int pos(int ch, int k);
    return (ch == 0) ? k + 3 : k;
  endfunction

  task automatic model_cycle(output logic hit);
    int kill;
    hit = 0;
    for (int c = 0; c < 2; c++) if (rx_last_rd[c]) m_p[pos(c, 2)] = 0;
    if (cmd_wr) begin
      kill = -1;
      if (cmd_code == 3'b010) begin kill = 0; hit = 1; end
      else if (cmd_code == 3'b101) begin kill = 1; hit = 1; end
      else if (cmd_code == 3'b111) begin
        hit = 1;
        for (int k = 2; k >= 0; k--)
          if (kill < 0 && m_p[pos(cmd_chan, k)]) kill = k;
      end
      if (kill >= 0) begin
        m_p[pos(cmd_chan, kill)] = 0;
        if (kill == 2 && !m_p[pos(1 - cmd_chan, 2)]) m_v[2] = 0;
        if (kill == 0 && !m_p[pos(1 - cmd_chan, 0)]) m_v[1] = 0;
      end
      if (hit) begin
        if (m_p[5:3] == 3'b000) m_v[3] = 0;
        if (m_p == 6'd0 && vis_en) m_v[3:1] = 3'b011;
      end
    end
    for (int c = 0; c < 2; c++) begin
      for (int k = 2; k >= 0; k--) begin
        bit fire;
        fire = (k == 2) ? (mie && rx_ie[c] && rx_arrive[c] && !m_p[pos(c, 2)]) :
               (k == 1) ? (tx_ie[c] && tx_done[c]) : (xs_ie[c] && xs_evt[c]);
        if (fire) begin
          if (vis_en) begin
            if (m_p == 6'd0) m_v[3:1] = 3'b000;
            if (k == 2) m_v[2] = 1;
            if (k == 0) m_v[1] = 1;
            if (c == 0) m_v[3] = 1;
          end
          m_p[pos(c, k)] = 1;
        end
      end
    end
  endtask

  task automatic push_exp(input logic hit, input string tag);
    exp_t e;
    e.p = {2'b00, m_p};
    e.v = {4'h0, m_v};
    e.i = (m_p != 6'd0);
    e.w = hit;
    e.tag = tag;
    q.push_back(e);
  endtask

  // driver: inputs already set at a falling edge
  task automatic step(input string tag);
    logic hit;
    @(posedge clk);
    model_cycle(hit);
    #1 push_exp(hit, tag);
    @(negedge clk);
    rx_arrive = 0; rx_last_rd = 0; tx_done = 0; xs_evt = 0; cmd_wr = 0;
  endtask

  task automatic cmd(input logic ch, input logic [2:0] code, input string tag);
    cmd_wr = 1; cmd_chan = ch; cmd_code = code;
    step(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (pend_rd !== e.p || vec_rd !== e.v || irq !== e.i || wr0_clr !== e.w) begin
        n_bad++;
        $display("FAIL %s: got pend=%h vec=%h irq=%b clr=%b exp pend=%h vec=%h irq=%b clr=%b",
                 e.tag, pend_rd, vec_rd, irq, wr0_clr, e.p, e.v, e.i, e.w);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mie = 0; vis_en = 0;
    rx_ie = 0; tx_ie = 0; xs_ie = 0;
    rx_arrive = 0; rx_last_rd = 0; tx_done = 0; xs_evt = 0;
    cmd_wr = 0; cmd_chan = 0; cmd_code = 0;
    m_p = 0; m_v = 4'b0110;
    repeat (3) @(posedge clk);
    #1 push_exp(1'b0, "R1 reset state");
    @(negedge clk);
    rst_n = 1;

    // R2: master enable off blocks receive
    rx_ie = 2'b01; rx_arrive = 2'b01; step("R2 mie low ignored");
    mie = 1; vis_en = 1;
    rx_arrive = 2'b01; step("R2 R4 rx A recorded, vector 0C");
    rx_arrive = 2'b01; step("R2 rx A already pending");
    // R3: transmit gated by enable
    tx_done = 2'b10; step("R3 tx B disabled");
    tx_ie = 2'b10; tx_done = 2'b10; step("R3 R4 tx B recorded");
    xs_ie = 2'b10; xs_evt = 2'b10; step("R3 R4 xs B recorded");
    xs_ie = 2'b00; xs_evt = 2'b01; step("R3 xs A disabled");
    // R7 R8: reset highest on A clears rx and channel A flag
    cmd(1'b0, 3'b111, "R7 R8 ius A clears rx");
    cmd(1'b1, 3'b111, "R7 ius B clears tx before xs");
    cmd(1'b0, 3'b010, "R5 xs reset A keeps flag for B");
    cmd(1'b1, 3'b001, "R12 unknown code ignored");
    cmd(1'b1, 3'b010, "R5 R9 xs reset B drains to default");
    // R4 R10 with status mode off
    vis_en = 0; rx_ie = 2'b11;
    rx_arrive = 2'b10; step("R4 vis off vector held");
    rx_last_rd = 2'b10; step("R10 last read clears rx B");
    // channel A transmit and external
    vis_en = 1; xs_ie = 2'b01; tx_ie = 2'b01;
    xs_evt = 2'b01; step("R4 xs A from empty");
    tx_done = 2'b01; step("R4 tx A adds no flag");
    cmd(1'b0, 3'b111, "R7 ius A tx before xs");
    tx_done = 2'b01; step("R3 tx A again");
    cmd(1'b0, 3'b101, "R6 tx reset A");
    cmd(1'b0, 3'b111, "R7 R8 R9 ius A xs drains");
    // both channels receive, cross-channel flag rule
    rx_arrive = 2'b11; step("R2 R4 rx both channels");
    cmd(1'b1, 3'b111, "R7 rx B cleared, flag kept for A");
    rx_last_rd = 2'b01; step("R10 last read A");
    cmd(1'b0, 3'b111, "R8 R9 ius A with nothing pending");
    tx_done = 2'b10; tx_ie = 2'b10; step("R4 R11 tx B from empty");
    cmd(1'b1, 3'b101, "R6 R11 tx reset B drains");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule